// File: doc/BRIEF.md
# Descriptor Ring Address Generator

This block produces the memory addresses a bus-master network controller uses to walk its transmit and receive descriptor rings. On an init strobe it captures a layout style, a base address and an entry count for each ring. From then on it keeps one current index per ring. A poll request returns the address of that ring's current entry. When the descriptor read comes back, the caller hands the ownership bit to the block. The block then either grants the entry, which moves the index on with wraparound, or reports that the host still holds it. In that case the same entry is polled again later.

Two layouts are supported. The legacy layout (style 0) uses 8-byte entries and an 8-byte aligned base, and its top address byte comes from an external control register. The wide layout (styles 1, 2 and 3) uses 16-byte entries, made of three 32-bit descriptor words and one reserved word, on a 16-byte aligned base. Entry counts set through the initialization path are capped per layout. Counts written through the direct path may go up to 65535.

Top module: `desc_ring_agu`

## Requirements
- R1: After reset both indices are 0, and addr_vld_o, grant_o, wait_o and align_err_o are 0.
- R2: A cycle with init_i high latches the style, both bases and both lengths, and clears both indices to 0 from the next cycle. Poll and ownership inputs in that cycle are ignored.
- R3: In style 0 (style_i == 0) a polled address is {upper_reg_i[15:8] at poll time, bits 23:0 of (aligned base + index*8)}.
- R4: In styles 1, 2 and 3 a polled address is aligned base + index*16, over the full 32 bits.
- R5: At init the base's low 3 bits (style 0) or low 4 bits (other styles) are forced to zero. align_err_o is set if either ring's base had any of those bits nonzero, and it holds until the next init.
- R6: With len_direct_i = 0 the effective length is min(len, 128) in style 0 and min(len, 512) otherwise. With len_direct_i = 1 the length is used as given (up to 65535). A length of 0 acts as 1.
- R7: The index of a ring steps from effective length - 1 back to 0.
- R8: own_vld_i with own_bit_i = 1 makes grant_o 1 in the next cycle and advances the index of the ring named by own_ring_i (0 = transmit, 1 = receive).
- R9: own_vld_i with own_bit_i = 0 makes wait_o 1 in the next cycle and leaves the index unchanged, so the next poll returns the same address.
- R10: poll_i makes addr_vld_o 1 in the next cycle, with addr_ring_o equal to the polled ring. Every address has bits 1:0 equal to 0, since descriptor words are fetched as 32-bit transfers.
- R11: An ownership return for one ring never changes the other ring's index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| style_i | input | 2 | Layout style, 0 = legacy, otherwise wide |
| len_direct_i | input | 1 | 1 = lengths come from the direct length registers |
| init_i | input | 1 | Latch configuration and clear indices |
| tx_base_i | input | 32 | Transmit ring base address |
| rx_base_i | input | 32 | Receive ring base address |
| tx_len_i | input | 16 | Transmit ring length in entries |
| rx_len_i | input | 16 | Receive ring length in entries |
| upper_reg_i | input | 16 | Control register, bits 15:8 give the legacy top address byte |
| poll_i | input | 1 | Request the current entry address |
| poll_ring_i | input | 1 | Ring polled, 0 = transmit, 1 = receive |
| own_vld_i | input | 1 | Ownership bit returned from a descriptor read |
| own_ring_i | input | 1 | Ring of the returned descriptor |
| own_bit_i | input | 1 | Ownership bit value, 1 = controller owns |
| addr_vld_o | output | 1 | Address valid |
| addr_ring_o | output | 1 | Ring of the address |
| addr_o | output | 32 | Descriptor entry address |
| grant_o | output | 1 | Entry owned by the controller, index advanced |
| wait_o | output | 1 | Entry held by the host, index kept |
| align_err_o | output | 1 | A base address was misaligned at the last init |
| tx_idx_o | output | 16 | Current transmit index |
| rx_idx_o | output | 16 | Current receive index |

## Verification
Every result is due one clock edge after the stimulus that causes it:
- the address after a poll;
- grant or wait and the new index after an ownership return;
- the cleared indices and the alignment flag after an init.

The bench drives each input on a falling edge, lets exactly one rising edge pass, and compares at the following falling edge against its own model. An op is never overlapped with the next, so each sample belongs to one stimulus. Long wrap runs at the 128, 512 and 700 entry limits are stepped one return at a time, with the index checked after each.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int unsigned LEG_SHIFT  = 3;
  localparam int unsigned WIDE_SHIFT = 4;
  localparam int unsigned HI_W       = 8;
  typedef enum logic {RING_TX = 1'b0, RING_RX = 1'b1} ring_e;
endpackage

// File: rtl/dring_cfg.sv
module dring_cfg import dring_pkg::*; #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned IDX_W    = 16,
  parameter int unsigned LEG_MAX  = 128,
  parameter int unsigned WIDE_MAX = 512
) (
  input  logic              leg_i,
  input  logic              direct_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  len_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [IDX_W-1:0]  len_o,
  output logic              mis_o
);
  localparam logic [IDX_W-1:0] LEG_MAX_V  = IDX_W'(LEG_MAX);
  localparam logic [IDX_W-1:0] WIDE_MAX_V = IDX_W'(WIDE_MAX);

  logic [IDX_W-1:0] cap, clamped;

  always_comb begin
    if (leg_i) begin
      mis_o  = |base_i[LEG_SHIFT-1:0];
      base_o = {base_i[ADDR_W-1:LEG_SHIFT], {LEG_SHIFT{1'b0}}};
    end else begin
      mis_o  = |base_i[WIDE_SHIFT-1:0];
      base_o = {base_i[ADDR_W-1:WIDE_SHIFT], {WIDE_SHIFT{1'b0}}};
    end
    cap     = leg_i ? LEG_MAX_V : WIDE_MAX_V;
    clamped = (!direct_i && (len_i > cap)) ? cap : len_i;
    len_o   = (clamped == '0) ? IDX_W'(1) : clamped;
  end
endmodule

// File: rtl/dring_ptr.sv
module dring_ptr #(
  parameter int unsigned IDX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] len_i,
  output logic [IDX_W-1:0] idx_o
);
  logic last;
  assign last = (idx_o >= len_i - IDX_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_o <= '0;
    else if (clr_i)  idx_o <= '0;
    else if (adv_i)  idx_o <= last ? '0 : idx_o + IDX_W'(1);
  end
endmodule

// File: rtl/dring_addr.sv
module dring_addr import dring_pkg::*; #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 16
) (
  input  logic              leg_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [HI_W-1:0]   hi_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] off, sum;

  always_comb begin
    off = leg_i ? (ADDR_W'(idx_i) << LEG_SHIFT) : (ADDR_W'(idx_i) << WIDE_SHIFT);
    sum = base_i + off;
    // legacy mode: top byte replaced by control register byte
    addr_o = leg_i ? {hi_i, sum[ADDR_W-HI_W-1:0]} : sum;
  end
endmodule

// File: rtl/desc_ring_agu.sv
module desc_ring_agu import dring_pkg::*; #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned IDX_W    = 16,
  parameter int unsigned LEG_MAX  = 128,
  parameter int unsigned WIDE_MAX = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        style_i,
  input  logic              len_direct_i,
  input  logic              init_i,
  input  logic [ADDR_W-1:0] tx_base_i,
  input  logic [ADDR_W-1:0] rx_base_i,
  input  logic [IDX_W-1:0]  tx_len_i,
  input  logic [IDX_W-1:0]  rx_len_i,
  input  logic [15:0]       upper_reg_i,
  input  logic              poll_i,
  input  logic              poll_ring_i,
  input  logic              own_vld_i,
  input  logic              own_ring_i,
  input  logic              own_bit_i,
  output logic              addr_vld_o,
  output logic              addr_ring_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              grant_o,
  output logic              wait_o,
  output logic              align_err_o,
  output logic [IDX_W-1:0]  tx_idx_o,
  output logic [IDX_W-1:0]  rx_idx_o
);
  localparam int unsigned NRING = 2;

  logic              leg_in, leg_q;
  logic [ADDR_W-1:0] base_in  [NRING];
  logic [ADDR_W-1:0] base_al  [NRING];
  logic [ADDR_W-1:0] base_q   [NRING];
  logic [IDX_W-1:0]  len_in   [NRING];
  logic [IDX_W-1:0]  len_eff  [NRING];
  logic [IDX_W-1:0]  len_q    [NRING];
  logic [IDX_W-1:0]  idx      [NRING];
  logic [NRING-1:0]  mis, adv;
  logic [ADDR_W-1:0] addr_nxt;
  logic              own_ok;

  assign leg_in     = (style_i == 2'd0);
  assign base_in[0] = tx_base_i;
  assign base_in[1] = rx_base_i;
  assign len_in[0]  = tx_len_i;
  assign len_in[1]  = rx_len_i;
  assign own_ok     = own_vld_i && !init_i;

  for (genvar r = 0; r < NRING; r++) begin : g_ring
    dring_cfg #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LEG_MAX(LEG_MAX), .WIDE_MAX(WIDE_MAX)
    ) u_cfg (
      .leg_i   (leg_in),
      .direct_i(len_direct_i),
      .base_i  (base_in[r]),
      .len_i   (len_in[r]),
      .base_o  (base_al[r]),
      .len_o   (len_eff[r]),
      .mis_o   (mis[r])
    );

    assign adv[r] = own_ok && own_bit_i && (own_ring_i == 1'(r));

    dring_ptr #(.IDX_W(IDX_W)) u_ptr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (init_i),
      .adv_i (adv[r]),
      .len_i (len_q[r]),
      .idx_o (idx[r])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[r] <= '0;
        len_q[r]  <= IDX_W'(1);
      end else if (init_i) begin
        base_q[r] <= base_al[r];
        len_q[r]  <= len_eff[r];
      end
    end
  end

  assign tx_idx_o = idx[RING_TX];
  assign rx_idx_o = idx[RING_RX];

  dring_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .leg_i (leg_q),
    .base_i(poll_ring_i ? base_q[1] : base_q[0]),
    .idx_i (poll_ring_i ? idx[1] : idx[0]),
    .hi_i  (upper_reg_i[15:8]),
    .addr_o(addr_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      leg_q       <= 1'b1;
      align_err_o <= 1'b0;
      addr_vld_o  <= 1'b0;
      addr_ring_o <= 1'b0;
      addr_o      <= '0;
      grant_o     <= 1'b0;
      wait_o      <= 1'b0;
    end else begin
      if (init_i) begin
        leg_q       <= leg_in;
        align_err_o <= |mis;
      end
      addr_vld_o <= poll_i && !init_i;
      if (poll_i && !init_i) begin
        addr_ring_o <= poll_ring_i;
        addr_o      <= addr_nxt;
      end
      grant_o <= own_ok && own_bit_i;
      wait_o  <= own_ok && !own_bit_i;
    end
  end
endmodule

// File: rtl/dring_chk.sv
module dring_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              init_i,
  input logic              poll_i,
  input logic              own_vld_i,
  input logic              own_ring_i,
  input logic              own_bit_i,
  input logic [15:0]       upper_reg_i,
  input logic              leg_q,
  input logic [IDX_W-1:0]  tx_len_q,
  input logic [IDX_W-1:0]  rx_len_q,
  input logic              addr_vld_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              grant_o,
  input logic              wait_o,
  input logic [IDX_W-1:0]  tx_idx_o,
  input logic [IDX_W-1:0]  rx_idx_o
);
  // R10
  addr_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_o |-> addr_o[1:0] == 2'b00);
  // R10
  poll_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_i && !init_i) |=> addr_vld_o);
  // R3
  leg_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_i && !init_i && leg_q) |=> addr_o[ADDR_W-1 -: 8] == $past(upper_reg_i[15:8]));
  // R9
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_vld_i && !own_bit_i && !own_ring_i && !init_i) |=> $stable(tx_idx_o));
  // R11
  rx_iso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_vld_i && !own_ring_i && !init_i) |=> $stable(rx_idx_o));
  // R7
  tx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_idx_o < tx_len_q);
  // R7
  rx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_idx_o < rx_len_q);
  // R8
  resp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_vld_i && !init_i) |=> (grant_o ^ wait_o));
endmodule

bind desc_ring_agu dring_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .init_i     (init_i),
  .poll_i     (poll_i),
  .own_vld_i  (own_vld_i),
  .own_ring_i (own_ring_i),
  .own_bit_i  (own_bit_i),
  .upper_reg_i(upper_reg_i),
  .leg_q      (leg_q),
  .tx_len_q   (len_q[0]),
  .rx_len_q   (len_q[1]),
  .addr_vld_o (addr_vld_o),
  .addr_o     (addr_o),
  .grant_o    (grant_o),
  .wait_o     (wait_o),
  .tx_idx_o   (tx_idx_o),
  .rx_idx_o   (rx_idx_o)
);

// File: tb/sim_desc_ring_agu.sv
module sim_desc_ring_agu;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0]  style_i = '0;
  logic        len_direct_i = 1'b0, init_i = 1'b0;
  logic [31:0] tx_base_i = '0, rx_base_i = '0;
  logic [15:0] tx_len_i = '0, rx_len_i = '0, upper_reg_i = '0;
  logic        poll_i = 1'b0, poll_ring_i = 1'b0;
  logic        own_vld_i = 1'b0, own_ring_i = 1'b0, own_bit_i = 1'b0;
  logic        addr_vld_o, addr_ring_o, grant_o, wait_o, align_err_o;
  logic [31:0] addr_o;
  logic [15:0] tx_idx_o, rx_idx_o;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;

  int unsigned m_idx [2];
  int unsigned m_len [2];
  logic [31:0] m_base [2];
  bit          m_leg, m_err;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  desc_ring_agu u0 (.*);

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      fails++; tests++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int unsigned eff_len(bit leg, bit direct, int unsigned len);
    int unsigned cap = leg ? 128 : 512;
    int unsigned e = (!direct && len > cap) ? cap : len;
    return (e == 0) ? 1 : e;
  endfunction

  function automatic logic [31:0] exp_addr(int r, logic [7:0] hi);
    logic [31:0] s;
    if (m_leg) begin
      s = m_base[r] + (m_idx[r] << 3);
      return {hi, s[23:0]};
    end
    return m_base[r] + (m_idx[r] << 4);
  endfunction

  task automatic check_idx(string tag);
    chk(tx_idx_o == m_idx[0][15:0], {tag, " tx_idx"}, 32'(tx_idx_o), m_idx[0]);
    chk(rx_idx_o == m_idx[1][15:0], {tag, " rx_idx"}, 32'(rx_idx_o), m_idx[1]);
  endtask

  task automatic do_init(logic [1:0] st, bit dir, logic [31:0] tb, logic [31:0] rb,
                         logic [15:0] tl, logic [15:0] rl);
    bit leg;
    leg = (st == 2'd0);
    @(negedge clk_i);
    style_i = st; len_direct_i = dir; tx_base_i = tb; rx_base_i = rb;
    tx_len_i = tl; rx_len_i = rl; init_i = 1'b1;
    @(negedge clk_i);
    init_i = 1'b0;
    m_leg = leg;
    m_err = leg ? ((tb[2:0] != 0) || (rb[2:0] != 0)) : ((tb[3:0] != 0) || (rb[3:0] != 0));
    m_base[0] = leg ? {tb[31:3], 3'b0} : {tb[31:4], 4'b0};
    m_base[1] = leg ? {rb[31:3], 3'b0} : {rb[31:4], 4'b0};
    m_len[0] = eff_len(leg, dir, tl);
    m_len[1] = eff_len(leg, dir, rl);
    m_idx[0] = 0; m_idx[1] = 0;
    // R2 R5
    chk(align_err_o == m_err, "R5 align_err", 32'(align_err_o), 32'(m_err));
    check_idx("R2 init");
  endtask

  task automatic do_poll(int r, logic [15:0] up);
    logic [31:0] e;
    @(negedge clk_i);
    poll_i = 1'b1; poll_ring_i = r[0]; upper_reg_i = up;
    e = exp_addr(r, up[15:8]);
    @(negedge clk_i);
    poll_i = 1'b0;
    // R10 R3 R4
    chk(addr_vld_o == 1'b1, "R10 addr_vld", 32'(addr_vld_o), 32'd1);
    chk(addr_ring_o == r[0], "R10 addr_ring", 32'(addr_ring_o), 32'(r[0]));
    chk(addr_o == e, m_leg ? "R3 legacy addr" : "R4 wide addr", addr_o, e);
    chk(addr_o[1:0] == 2'b00, "R10 word align", 32'(addr_o[1:0]), 32'd0);
  endtask

  task automatic do_own(int r, bit b);
    @(negedge clk_i);
    own_vld_i = 1'b1; own_ring_i = r[0]; own_bit_i = b;
    @(negedge clk_i);
    own_vld_i = 1'b0;
    if (b) begin
      m_idx[r] = (m_idx[r] >= m_len[r] - 1) ? 0 : m_idx[r] + 1;
      chk(grant_o && !wait_o, "R8 grant", {30'd0, grant_o, wait_o}, 32'd2);
    end else begin
      chk(wait_o && !grant_o, "R9 wait", {30'd0, grant_o, wait_o}, 32'd1);
    end
    // R7 R8 R9 R11
    check_idx(b ? "R8 R11 adv" : "R9 R11 hold");
  endtask

  initial begin
    void'($urandom(32'd4242));
    #(CLK_PERIOD*2 + 2);
    @(negedge clk_i);
    // R1 (the time-zero sample is taken while reset is still held)
    chk(tx_idx_o == 0 && rx_idx_o == 0, "R1 idx", {tx_idx_o, rx_idx_o}, 32'd0);
    chk({addr_vld_o, grant_o, wait_o, align_err_o} == 4'd0, "R1 flags",
        32'({addr_vld_o, grant_o, wait_o, align_err_o}), 32'd0);
    rst_ni = 1'b1;

    // legacy, misaligned tx base, short rings
    do_init(2'd0, 1'b0, 32'h0012_3405, 32'h0000_1000, 16'd5, 16'd3);
    do_poll(0, 16'hAB00);
    for (int i = 0; i < 6; i++) begin do_own(0, 1'b1); do_poll(0, 16'hAB00); end  // R7 wrap
    do_own(1, 1'b1);
    do_own(1, 1'b0);                                  // R9
    do_poll(1, 16'h5A77);
    do_poll(1, 16'h5A77);

    // wide, init path 600 -> 512 (R6)
    do_init(2'd2, 1'b0, 32'h8000_0010, 32'h4000_0020, 16'd600, 16'd2);
    for (int i = 0; i < 511; i++) do_own(0, 1'b1);
    do_poll(0, 16'h0);
    do_own(0, 1'b1);                                  // R6 R7 back to 0
    do_poll(0, 16'h0);

    // wide direct 700 (R6), misaligned rx base
    do_init(2'd3, 1'b1, 32'h0000_0100, 32'h0000_2008, 16'd3, 16'd700);
    for (int i = 0; i < 700; i++) do_own(1, 1'b1);
    do_poll(1, 16'h0);

    // legacy init 200 -> 128, length 0 -> 1
    do_init(2'd0, 1'b0, 32'h0000_0040, 32'h0000_0080, 16'd200, 16'd0);
    for (int i = 0; i < 128; i++) do_own(0, 1'b1);
    do_own(1, 1'b1);
    do_own(1, 1'b1);
    do_poll(1, 16'hFF00);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = int'($urandom_range(0, 19));
      if (op == 0)
        do_init(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), $urandom, $urandom,
                16'($urandom_range(0, 20)), 16'($urandom_range(0, 20)));
      else if (op < 8)
        do_poll(int'($urandom_range(0, 1)), 16'($urandom));
      else
        do_own(int'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule